// File: doc/BRIEF.md
# Two-Channel Current Balance and Load Monitor

This block sits between a pair of channel-current samplers and the pulse-width logic of a two-phase power train that runs from one input pulse stream. Each time a fresh pair of unsigned current codes arrives with its strobe, the block updates three things:

- **Load monitor.** The mean of the two codes becomes the load-current monitor word. The word saturates at a full-scale code that stands for 100 µA.
- **Turn-off extension codes.** Each channel gets a code that stretches its turn-off edge. The stretch runs from 0 to 70 ns, in 1 ns steps. A channel carrying less than the mean is stretched more, and a channel carrying more than the mean is stretched less. The difference in duty pulls the two currents together.
- **Overvoltage flag.** The flag reports a channel current above 60 % of monitor full scale. It is only evaluated while the block is armed. The block arms when the enable input rises while the pulse input is low, and it stays armed until the pulse input goes high or the enable drops.

The system scales the monitor so that normal full load lands at about 50 to 80 µA. A sample above the 60 % mark while armed therefore means a channel is conducting when it should be idle, for example through a shorted high-side switch.

Top module: `dual_phase_balance`

## Requirements
- R1: After reset the monitor word is 0, both extension codes sit at the midpoint code TRIM_MID = EXT_MAX/2 (35 with EXT_MAX = 70), and the fault flag is 0.
- R2: One clock after a strobe, the monitor word equals floor((A+B)/2) whenever that value does not exceed MON_FS.
- R3: When floor((A+B)/2) exceeds MON_FS, the monitor word equals MON_FS (it saturates and never wraps).
- R4: One clock after a strobe, each channel's extension code equals clamp(TRIM_MID + (floor((A+B)/2) − own current) × 2^GAIN_SH, 0, EXT_MAX). The unsaturated mean is used here. Code value n means an n ns stretch.
- R5: Equal channel currents give both channels TRIM_MID. The lower-current channel never receives a smaller code than the higher-current channel.
- R6: While the strobe is low, the monitor word, both extension codes and the fault flag hold their values, whatever the current inputs do.
- R7: On a strobe while armed, the fault flag becomes 1 if A or B is strictly greater than OV_LIM = floor(3·MON_FS/5), and 0 otherwise. A strobe while not armed sets the flag to 0.
- R8: The block counts as armed in any cycle where the enable is high, the pulse input is low, and either the enable rose in that cycle or the block has been armed in every cycle since such a rise. Once the pulse input goes high, or the enable falls, the block is disarmed until the next rise of the enable while the pulse input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld_i | input | 1 | Strobe: a new current pair is present |
| cur_a_i | input | CUR_W | Channel A current code |
| cur_b_i | input | CUR_W | Channel B current code |
| en_i | input | 1 | Block enable, sampled for rising edge |
| pwm_i | input | 1 | Input pulse level, used for arming |
| mon_o | output | CUR_W | Saturated mean current (load monitor) |
| ext_a_o | output | EXT_W | Channel A turn-off extension, ns |
| ext_b_o | output | EXT_W | Channel B turn-off extension, ns |
| ovp_o | output | 1 | Overvoltage fault flag |

## Verification
The properties assume that the enable, pulse and strobe inputs are stable across each clock edge, and that MON_FS and EXT_MAX fit their widths. The bench meets these assumptions by changing every input only on the falling edge. It uses a small configuration (6-bit currents, MON_FS = 50), so that it can sweep every A/B pair and compute the mean, the saturation point, and both clamped trims with plain integer arithmetic. The arming sequences are stepped one cycle at a time. They cover an enable rise with the pulse high, a pulse that rises after arming, and currents sitting exactly on and one code above the 60 % mark.

// File: rtl/dpb_pkg.sv
// Package: shared helpers for the two-channel balance block.
// Assumes callers pass values that fit in a 32-bit signed int.
package dpb_pkg;

    // Limit v to the closed range [lo, hi].
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

endpackage

// File: rtl/dpb_mean.sv
// Module: dpb_mean
// Forms the floor mean of two channel codes. The raw mean goes out
// combinationally to the trim stages. A saturated copy is registered
// as the monitor word on each strobe.
// Assumes MON_FS <= 2**CUR_W - 1.
module dpb_mean #(
    parameter int CUR_W  = 8,
    parameter int MON_FS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [CUR_W-1:0] a_i,
    input  logic [CUR_W-1:0] b_i,
    output logic [CUR_W-1:0] avg_raw_o,
    output logic [CUR_W-1:0] mon_o
);
    localparam int SUM_W = CUR_W + 1;
    localparam logic [CUR_W-1:0] FS_CODE = CUR_W'(MON_FS);

    logic [SUM_W-1:0] sum;
    logic [CUR_W-1:0] mon_d;

    // Sum and halve: the raw mean used as the balance reference.
    always_comb begin
        sum       = {1'b0, a_i} + {1'b0, b_i};
        avg_raw_o = sum[SUM_W-1:1];
    end

    // Saturate the mean at the monitor full-scale code.
    always_comb begin
        mon_d = (avg_raw_o > FS_CODE) ? FS_CODE : avg_raw_o;
    end

    // Capture the monitor word on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mon_o <= '0;
        else if (vld_i)
            mon_o <= mon_d;
    end
endmodule

// File: rtl/dpb_trim.sv
// Module: dpb_trim
// Computes one channel's turn-off extension from how far its current
// sits from the mean. The code is centred on the midpoint, scaled by a
// power-of-two gain, clamped to [0, EXT_MAX], and registered on a strobe.
// Assumes the mean and the channel code share the same width.
module dpb_trim #(
    parameter int CUR_W   = 8,
    parameter int EXT_MAX = 70,
    parameter int GAIN_SH = 1,
    parameter int EXT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [CUR_W-1:0] avg_i,
    input  logic [CUR_W-1:0] cur_i,
    output logic [EXT_W-1:0] ext_o
);
    import dpb_pkg::*;

    localparam int TRIM_MID = EXT_MAX / 2;
    localparam int GAIN     = 1 << GAIN_SH;

    int               err;
    int               raw;
    logic [EXT_W-1:0] ext_d;

    // Signed error: positive when this channel is below the mean.
    always_comb begin
        err   = int'(avg_i) - int'(cur_i);
        raw   = TRIM_MID + err * GAIN;
        ext_d = EXT_W'(clamp_int(raw, 0, EXT_MAX));
    end

    // Register the extension on a strobe; start balanced at the midpoint.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_o <= EXT_W'(TRIM_MID);
        else if (vld_i)
            ext_o <= ext_d;
    end
endmodule

// File: rtl/dpb_ovp.sv
// Module: dpb_ovp
// Tracks the arming window and flags a channel current above 60 % of
// monitor full scale. The window opens when the enable rises with the
// pulse input low, and closes when the pulse goes high or the enable
// drops. The flag is re-evaluated on each strobe.
// Assumes en_i and pwm_i are already synchronous to clk.
module dpb_ovp #(
    parameter int CUR_W  = 8,
    parameter int MON_FS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             en_i,
    input  logic             pwm_i,
    input  logic [CUR_W-1:0] a_i,
    input  logic [CUR_W-1:0] b_i,
    output logic             ovp_o
);
    localparam int OV_LIM = (MON_FS * 3) / 5;
    localparam logic [CUR_W-1:0] LIM_CODE = CUR_W'(OV_LIM);

    logic en_q;
    logic armed_q;
    logic en_rise;
    logic armed_now;
    logic over;

    // Decode the enable edge and the live arming condition.
    always_comb begin
        en_rise   = en_i & ~en_q;
        armed_now = (armed_q | en_rise) & en_i & ~pwm_i;
        over      = (a_i > LIM_CODE) | (b_i > LIM_CODE);
    end

    // Remember the previous enable level and the arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            en_q    <= en_i;
            armed_q <= armed_now;
        end
    end

    // Update the fault flag on each strobe and hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovp_o <= 1'b0;
        else if (vld_i)
            ovp_o <= armed_now & over;
    end
endmodule

// File: rtl/dual_phase_balance.sv
// Module: dual_phase_balance (top)
// Two-channel current balance and load monitor. It produces the mean
// monitor word, one turn-off extension per channel, and an armed
// overvoltage flag. All outputs update one clock after a strobe.
// Assumes MON_FS < 2**CUR_W and EXT_MAX < 2**EXT_W.
module dual_phase_balance #(
    parameter int CUR_W   = 8,
    parameter int MON_FS  = 200,
    parameter int EXT_MAX = 70,
    parameter int GAIN_SH = 1,
    parameter int EXT_W   = $clog2(EXT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld_i,
    input  logic [CUR_W-1:0] cur_a_i,
    input  logic [CUR_W-1:0] cur_b_i,
    input  logic             en_i,
    input  logic             pwm_i,
    output logic [CUR_W-1:0] mon_o,
    output logic [EXT_W-1:0] ext_a_o,
    output logic [EXT_W-1:0] ext_b_o,
    output logic             ovp_o
);
    localparam int N_CH = 2;

    logic [CUR_W-1:0] avg_raw;
    logic [CUR_W-1:0] cur_arr [N_CH];
    logic [EXT_W-1:0] ext_arr [N_CH];

    // Gather the channel inputs into an array for the trim instances.
    always_comb begin
        cur_arr[0] = cur_a_i;
        cur_arr[1] = cur_b_i;
    end

    dpb_mean #(
        .CUR_W  (CUR_W),
        .MON_FS (MON_FS)
    ) u_mean (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (sample_vld_i),
        .a_i       (cur_a_i),
        .b_i       (cur_b_i),
        .avg_raw_o (avg_raw),
        .mon_o     (mon_o)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_trim
        dpb_trim #(
            .CUR_W   (CUR_W),
            .EXT_MAX (EXT_MAX),
            .GAIN_SH (GAIN_SH),
            .EXT_W   (EXT_W)
        ) u_trim (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (sample_vld_i),
            .avg_i (avg_raw),
            .cur_i (cur_arr[c]),
            .ext_o (ext_arr[c])
        );
    end

    // Map the per-channel extensions back onto the named ports.
    always_comb begin
        ext_a_o = ext_arr[0];
        ext_b_o = ext_arr[1];
    end

    dpb_ovp #(
        .CUR_W  (CUR_W),
        .MON_FS (MON_FS)
    ) u_ovp (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (sample_vld_i),
        .en_i  (en_i),
        .pwm_i (pwm_i),
        .a_i   (cur_a_i),
        .b_i   (cur_b_i),
        .ovp_o (ovp_o)
    );
endmodule

// File: rtl/dual_phase_balance_chk.sv
// Module: dual_phase_balance_chk
// Property checker for dual_phase_balance, attached with bind.
// Assumes the bound parameters match those of the instance.
module dual_phase_balance_chk #(
    parameter int CUR_W   = 8,
    parameter int MON_FS  = 200,
    parameter int EXT_MAX = 70,
    parameter int EXT_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_vld_i,
    input logic [CUR_W-1:0] cur_a_i,
    input logic [CUR_W-1:0] cur_b_i,
    input logic             en_i,
    input logic [CUR_W-1:0] mon_o,
    input logic [EXT_W-1:0] ext_a_o,
    input logic [EXT_W-1:0] ext_b_o,
    input logic             ovp_o
);
    localparam logic [EXT_W-1:0] MID_CODE = EXT_W'(EXT_MAX / 2);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_i |=> ($stable(mon_o) && $stable(ext_a_o)
                           && $stable(ext_b_o) && $stable(ovp_o)));

    assert_mon_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mon_o <= CUR_W'(MON_FS));

    assert_ext_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_a_o <= EXT_W'(EXT_MAX)) && (ext_b_o <= EXT_W'(EXT_MAX)));

    assert_equal_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && cur_a_i == cur_b_i) |=>
            (ext_a_o == MID_CODE && ext_b_o == MID_CODE));

    assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && cur_a_i < cur_b_i) |=> (ext_a_o >= ext_b_o));

    assert_disabled_noflt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && !en_i) |=> !ovp_o);
endmodule

bind dual_phase_balance dual_phase_balance_chk #(
    .CUR_W   (CUR_W),
    .MON_FS  (MON_FS),
    .EXT_MAX (EXT_MAX),
    .EXT_W   (EXT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld_i (sample_vld_i),
    .cur_a_i      (cur_a_i),
    .cur_b_i      (cur_b_i),
    .en_i         (en_i),
    .mon_o        (mon_o),
    .ext_a_o      (ext_a_o),
    .ext_b_o      (ext_b_o),
    .ovp_o        (ovp_o)
);

// File: tb/dual_phase_balance_bench.sv
// Bench: exhaustive sweep of a 6-bit configuration plus arming sequences.
module dual_phase_balance_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CUR_W      = 6;
    localparam int MON_FS     = 50;
    localparam int EXT_MAX    = 70;
    localparam int GAIN_SH    = 1;
    localparam int EXT_W      = $clog2(EXT_MAX + 1);
    localparam int MID        = EXT_MAX / 2;
    localparam int OV_LIM     = (MON_FS * 3) / 5;
    localparam int MAXV       = (1 << CUR_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vld = 1'b0;
    logic [CUR_W-1:0] a = '0;
    logic [CUR_W-1:0] b = '0;
    logic             en = 1'b0;
    logic             pwm = 1'b0;
    logic [CUR_W-1:0] mon;
    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;
    logic             ovp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dual_phase_balance #(
        .CUR_W   (CUR_W),
        .MON_FS  (MON_FS),
        .EXT_MAX (EXT_MAX),
        .GAIN_SH (GAIN_SH)
    ) u_dual_phase_balance (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld_i (vld),
        .cur_a_i      (a),
        .cur_b_i      (b),
        .en_i         (en),
        .pwm_i        (pwm),
        .mon_o        (mon),
        .ext_a_o      (ext_a),
        .ext_b_o      (ext_b),
        .ovp_o        (ovp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ext(input int av, input int own);
        int t;
        t = MID + (av - own) * (1 << GAIN_SH);
        if (t < 0) t = 0;
        if (t > EXT_MAX) t = EXT_MAX;
        return t;
    endfunction

    // Present one strobed pair; return at the falling edge after capture.
    task automatic strobe(input int va, input int vb);
        @(negedge clk);
        a   = CUR_W'(va);
        b   = CUR_W'(vb);
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic step_ctl(input logic e, input logic p);
        @(negedge clk);
        en  = e;
        pwm = p;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int av, em, lo_ext, hi_ext;
        repeat (3) @(negedge clk);
        chk("R1 mon reset", int'(mon), 0);
        chk("R1 ext_a reset", int'(ext_a), MID);
        chk("R1 ext_b reset", int'(ext_b), MID);
        chk("R1 ovp reset", int'(ovp), 0);
        rst_n = 1'b1;

        // Full sweep with the block disarmed.
        for (int i = 0; i <= MAXV; i++) begin
            for (int j = 0; j <= MAXV; j++) begin
                strobe(i, j);
                av = (i + j) / 2;
                em = (av > MON_FS) ? MON_FS : av;
                if (av > MON_FS) chk("R3 mon saturate", int'(mon), em);
                else             chk("R2 mon mean", int'(mon), em);
                chk("R4 ext_a", int'(ext_a), exp_ext(av, i));
                chk("R4 ext_b", int'(ext_b), exp_ext(av, j));
                lo_ext = (i <= j) ? int'(ext_a) : int'(ext_b);
                hi_ext = (i <= j) ? int'(ext_b) : int'(ext_a);
                if (i == j) chk("R5 equal mid", int'(ext_a), MID);
                chk("R5 order", int'(lo_ext >= hi_ext), 1);
                chk("R7 unarmed no fault", int'(ovp), 0);
            end
        end

        // R6 hold: inputs move with the strobe low.
        strobe(10, 40);
        @(negedge clk);
        a = 63; b = 0;
        @(negedge clk);
        chk("R6 hold mon", int'(mon), 25);
        chk("R6 hold ext_a", int'(ext_a), exp_ext(25, 10));
        chk("R6 hold ext_b", int'(ext_b), exp_ext(25, 40));

        // Arm: enable rises with the pulse low.
        step_ctl(1'b0, 1'b0);
        step_ctl(1'b1, 1'b0);
        strobe(OV_LIM + 1, 0);
        chk("R7 fault A above limit", int'(ovp), 1);
        strobe(OV_LIM, OV_LIM);
        chk("R7 at limit no fault", int'(ovp), 0);
        strobe(0, OV_LIM + 1);
        chk("R7 fault B above limit", int'(ovp), 1);
        @(negedge clk);
        a = 0; b = 0;
        @(negedge clk);
        chk("R6 fault held", int'(ovp), 1);

        // Pulse goes high: disarmed, stays disarmed after it drops.
        step_ctl(1'b1, 1'b1);
        strobe(MAXV, MAXV);
        chk("R8 pulse high disarms", int'(ovp), 0);
        step_ctl(1'b1, 1'b0);
        strobe(MAXV, MAXV);
        chk("R8 stays disarmed", int'(ovp), 0);

        // Enable rise while pulse high does not arm.
        step_ctl(1'b0, 1'b1);
        step_ctl(1'b1, 1'b1);
        step_ctl(1'b1, 1'b0);
        strobe(MAXV, 0);
        chk("R8 rise with pulse high", int'(ovp), 0);

        // Strobe in the same cycle as the enable rise counts as armed.
        step_ctl(1'b0, 1'b0);
        @(negedge clk);
        en = 1'b1; a = CUR_W'(MAXV); b = 0; vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        chk("R8 armed on rise cycle", int'(ovp), 1);

        // Enable falls: disarmed.
        step_ctl(1'b0, 1'b0);
        strobe(MAXV, MAXV);
        chk("R8 enable low disarms", int'(ovp), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule